// File: doc/BRIEF.md
# Shared-Bus Memory Bank Selector

This block sits between a host bus and a package that puts a flash bank and a static RAM bank on one shared address bus, one shared 16-bit data bus and shared output-enable and write-enable strobes. From three bank-enable inputs it works out which bank, if any, owns the current cycle. The flash has one active-low enable. The RAM has a pair of enables with opposite polarity. The block then turns the shared strobes into per-bank read and write enables.

For the RAM it also gates each byte lane of the data path on its own active-low lane control. It produces a per-lane enable for the data-bus output drivers. It gives each bank its own view of the address. Two registered flags report the state of the enables. The standby flag shows that no bank is selected. The sticky contention flag records any cycle in which both banks were selected together. In such a cycle the block keeps both banks off the bus.

Top module: `shb_bank_selector`

## Requirements
- R1: The flash is selected when `fl_en_n` is 0 and the RAM is not also selected. A selected flash gives `fl_rd`=1 when `oe_n`=0 and `we_n`=1, and gives `fl_wr`=1 when `we_n`=0.
- R2: The RAM is selected only when `ram_en1_n`=0 and `ram_en2`=1 in the same cycle. A selected RAM gives `ram_rd`=1 when `oe_n`=0 and `we_n`=1, and gives `ram_wr`=1 when `we_n`=0. With any other combination of the two RAM enables, every RAM output is 0.
- R3: `standby` is a registered output. One clock after the input condition, it is 1 when `fl_en_n`=1 and either `ram_en1_n`=1 or `ram_en2`=0. Otherwise it is 0.
- R4: When the flash and the RAM are both selected, every read enable, write enable, lane enable and `bus_oe` bit is 0 in that same cycle.
- R5: `contention` becomes 1 on the clock edge after any cycle with both banks selected, even a single such cycle. It then stays 1 until reset.
- R6: When `we_n`=0 and `oe_n`=0 together, the write enable of the selected bank is 1. `fl_rd`, `ram_rd`, `ram_lane_rd` and `bus_oe` are all 0.
- R7: `ram_byte_n[1]` gates the upper lane (data bits 15:8) and `ram_byte_n[0]` gates the lower lane (data bits 7:0). `ram_lane_rd[i]` = `ram_rd` AND NOT `ram_byte_n[i]`, and `ram_lane_wr[i]` = `ram_wr` AND NOT `ram_byte_n[i]`. The lane controls have no effect on flash accesses.
- R8: `bus_oe[i]` enables the data drivers of lane i. All lanes are 0 when `oe_n`=1 or no bank is selected. A flash read drives both lanes. A RAM read drives only the lanes that its lane controls enable.
- R9: `fl_addr` carries all 20 address bits. `ram_addr` carries address bits 18:0, so the RAM sees the lowest 512K-word region.
- R10: While `rst_n` is 0, `standby` and `contention` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status flags |
| rst_n | input | 1 | Active-low asynchronous reset |
| fl_en_n | input | 1 | Flash bank enable, active low |
| ram_en1_n | input | 1 | First RAM enable, active low |
| ram_en2 | input | 1 | Second RAM enable, active high |
| oe_n | input | 1 | Shared output enable, active low |
| we_n | input | 1 | Shared write enable, active low |
| ram_byte_n | input | 2 | RAM lane controls, active low; bit 1 upper, bit 0 lower |
| addr | input | 20 | Shared word address |
| fl_rd | output | 1 | Flash read enable |
| fl_wr | output | 1 | Flash write enable |
| ram_rd | output | 1 | RAM read enable |
| ram_wr | output | 1 | RAM write enable |
| ram_lane_rd | output | 2 | Per-lane RAM read enable |
| ram_lane_wr | output | 2 | Per-lane RAM write enable |
| bus_oe | output | 2 | Per-lane data-bus driver enable |
| fl_addr | output | 20 | Address to the flash bank |
| ram_addr | output | 19 | Address to the RAM bank |
| standby | output | 1 | Registered: no bank selected |
| contention | output | 1 | Registered, sticky: both banks were selected together |

## Verification
A wrong selection decode shows at the enable and `bus_oe` ports in the same cycle as the stimulus, because that path has no register. The bench therefore reads those outputs right after each input change. Either flag register, if wrong, shows one clock later. A `standby` that lags or leads, or a `contention` that clears itself after a violation, shows as a mismatch at the next edge and at every later edge. The sticky flag is held through several quiet cycles to show that it stays set.

// File: rtl/shb_pkg.sv
package shb_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_FLASH = 2'd1,
    SEL_RAM   = 2'd2,
    SEL_CLASH = 2'd3
  } bank_sel_e;

  // RAM needs its low-active and high-active enables both asserted
  function automatic logic ram_requested(input logic en1_n, input logic en2);
    return (!en1_n) && en2;
  endfunction

  function automatic logic flash_requested(input logic en_n);
    return !en_n;
  endfunction

  function automatic bank_sel_e pick_bank(input logic fl_req, input logic ram_req);
    bank_sel_e s;
    case ({fl_req, ram_req})
      2'b10:   s = SEL_FLASH;
      2'b01:   s = SEL_RAM;
      2'b11:   s = SEL_CLASH;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

  // read strobe only counts when no write is underway
  function automatic logic read_strobe(input logic oe_n, input logic we_n);
    return (!oe_n) && we_n;
  endfunction

  function automatic logic write_strobe(input logic we_n);
    return !we_n;
  endfunction

endpackage

// File: rtl/shb_bank_decode.sv
module shb_bank_decode
  import shb_pkg::*;
(
  input  logic      fl_en_n,
  input  logic      ram_en1_n,
  input  logic      ram_en2,
  input  logic      oe_n,
  input  logic      we_n,
  output bank_sel_e sel,
  output logic      fl_rd,
  output logic      fl_wr,
  output logic      ram_rd,
  output logic      ram_wr,
  output logic      clash,
  output logic      idle
);

  logic fl_req;
  logic ram_req;
  logic rd_stb;
  logic wr_stb;

  always_comb begin
    fl_req  = flash_requested(fl_en_n);
    ram_req = ram_requested(ram_en1_n, ram_en2);
    sel     = pick_bank(fl_req, ram_req);
    rd_stb  = read_strobe(oe_n, we_n);
    wr_stb  = write_strobe(we_n);
    fl_rd   = (sel == SEL_FLASH) && rd_stb;
    fl_wr   = (sel == SEL_FLASH) && wr_stb;
    ram_rd  = (sel == SEL_RAM) && rd_stb;
    ram_wr  = (sel == SEL_RAM) && wr_stb;
    clash   = (sel == SEL_CLASH);
    idle    = (sel == SEL_NONE);
  end

  // write strobe wins over a simultaneous read strobe
  always_comb begin
    if (!we_n && !oe_n) begin
      assert_write_wins_R6: assert (!fl_rd && !ram_rd);
    end
  end

  // a clash leaves both banks without any enable
  always_comb begin
    if (!fl_en_n && !ram_en1_n && ram_en2) begin
      assert_clash_quiet_R4: assert (!fl_rd && !fl_wr && !ram_rd && !ram_wr);
    end
  end

  // RAM enables need the opposite-polarity pair
  always_comb begin
    if (ram_en1_n || !ram_en2) begin
      assert_ram_pair_R2: assert (!ram_rd && !ram_wr);
    end
  end

endmodule

// File: rtl/shb_lane_gate.sv
module shb_lane_gate #(
  parameter int LANES = 2
) (
  input  logic             fl_rd,
  input  logic             ram_rd,
  input  logic             ram_wr,
  input  logic [LANES-1:0] byte_n,
  output logic [LANES-1:0] lane_rd,
  output logic [LANES-1:0] lane_wr,
  output logic [LANES-1:0] bus_oe
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic lane_on;
    assign lane_on    = !byte_n[i];
    assign lane_rd[i] = ram_rd && lane_on;
    assign lane_wr[i] = ram_wr && lane_on;
    // flash always uses the whole word; RAM only the enabled lanes
    assign bus_oe[i]  = fl_rd || lane_rd[i];

    always_comb begin
      if (byte_n[i] && !fl_rd) begin
        assert_lane_gated_R7: assert (!bus_oe[i] && !lane_wr[i]);
      end
    end
  end

endmodule

// File: rtl/shb_status_flags.sv
module shb_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clash,
  input  logic idle,
  output logic standby,
  output logic contention
);

  logic standby_q;
  logic contention_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      standby_q    <= 1'b0;
      contention_q <= 1'b0;
    end else begin
      standby_q    <= idle;
      contention_q <= contention_q | clash;
    end
  end

  assign standby    = standby_q;
  assign contention = contention_q;

  assert_clash_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> contention);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    contention |=> contention);

  assert_standby_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> standby);

  assert_standby_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> !standby);

endmodule

// File: rtl/shb_bank_selector.sv
module shb_bank_selector
  import shb_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int RAM_ADDR_W = 19,
  parameter int DATA_W     = 16,
  parameter int LANE_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fl_en_n,
  input  logic                      ram_en1_n,
  input  logic                      ram_en2,
  input  logic                      oe_n,
  input  logic                      we_n,
  input  logic [DATA_W/LANE_W-1:0]  ram_byte_n,
  input  logic [ADDR_W-1:0]         addr,
  output logic                      fl_rd,
  output logic                      fl_wr,
  output logic                      ram_rd,
  output logic                      ram_wr,
  output logic [DATA_W/LANE_W-1:0]  ram_lane_rd,
  output logic [DATA_W/LANE_W-1:0]  ram_lane_wr,
  output logic [DATA_W/LANE_W-1:0]  bus_oe,
  output logic [ADDR_W-1:0]         fl_addr,
  output logic [RAM_ADDR_W-1:0]     ram_addr,
  output logic                      standby,
  output logic                      contention
);

  localparam int LANES = DATA_W / LANE_W;

  bank_sel_e sel;
  logic      clash;
  logic      idle;

  shb_bank_decode u_decode (
    .fl_en_n   (fl_en_n),
    .ram_en1_n (ram_en1_n),
    .ram_en2   (ram_en2),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .sel       (sel),
    .fl_rd     (fl_rd),
    .fl_wr     (fl_wr),
    .ram_rd    (ram_rd),
    .ram_wr    (ram_wr),
    .clash     (clash),
    .idle      (idle)
  );

  shb_lane_gate #(.LANES(LANES)) u_lanes (
    .fl_rd   (fl_rd),
    .ram_rd  (ram_rd),
    .ram_wr  (ram_wr),
    .byte_n  (ram_byte_n),
    .lane_rd (ram_lane_rd),
    .lane_wr (ram_lane_wr),
    .bus_oe  (bus_oe)
  );

  shb_status_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .clash      (clash),
    .idle       (idle),
    .standby    (standby),
    .contention (contention)
  );

  // RAM lives in the lowest region: drop the upper address bits
  assign fl_addr  = addr;
  assign ram_addr = addr[RAM_ADDR_W-1:0];

  // the two banks never both hold an enable
  assert_one_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !((fl_rd || fl_wr) && (ram_rd || ram_wr)));

  // no drivers while the output enable is released
  assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (bus_oe == '0));

  // selection code is consistent with the enables it produced
  assert_sel_flash_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd || fl_wr) |-> (sel == SEL_FLASH) && !idle);

endmodule

// File: tb/shb_bank_selector_bench.sv
module shb_bank_selector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // stimulus {fl_en_n, ram_en1_n, ram_en2, oe_n, we_n, byte_n[1], byte_n[0]}
  // expect   {fl_rd, fl_wr, ram_rd, ram_wr, lane_rd[1:0], lane_wr[1:0], bus_oe[1:0], standby}
  localparam logic [17:0] VEC [NVEC] = '{
    {7'b0_1_0_0_1_0_0, 11'b1_0_0_0_00_00_11_0}, // flash read
    {7'b0_1_0_1_0_0_0, 11'b0_1_0_0_00_00_00_0}, // flash write
    {7'b0_1_0_0_0_1_1, 11'b0_1_0_0_00_00_00_0}, // flash oe+we: write wins
    {7'b1_0_1_0_1_0_0, 11'b0_0_1_0_11_00_11_0}, // RAM read both lanes
    {7'b1_0_1_0_1_0_1, 11'b0_0_1_0_10_00_10_0}, // RAM read upper
    {7'b1_0_1_0_1_1_0, 11'b0_0_1_0_01_00_01_0}, // RAM read lower
    {7'b1_0_1_0_1_1_1, 11'b0_0_1_0_00_00_00_0}, // RAM read no lanes
    {7'b1_0_1_1_0_1_0, 11'b0_0_0_1_00_01_00_0}, // RAM write lower
    {7'b1_0_1_0_0_0_0, 11'b0_0_0_1_00_11_00_0}, // RAM oe+we: write wins
    {7'b1_1_1_0_1_0_0, 11'b0_0_0_0_00_00_00_1}, // standby by first RAM enable
    {7'b1_0_0_0_1_0_0, 11'b0_0_0_0_00_00_00_1}, // standby by second RAM enable
    {7'b1_0_1_1_1_0_0, 11'b0_0_0_0_00_00_00_0}, // RAM selected, idle strobes
    {7'b0_1_0_1_1_0_0, 11'b0_0_0_0_00_00_00_0}, // flash selected, idle strobes
    {7'b0_0_0_0_1_1_1, 11'b1_0_0_0_00_00_11_0}  // flash read, lane bits ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fl_en_n = 1'b1;
  logic        ram_en1_n = 1'b1;
  logic        ram_en2 = 1'b0;
  logic        oe_n = 1'b1;
  logic        we_n = 1'b1;
  logic [1:0]  ram_byte_n = 2'b11;
  logic [19:0] addr = '0;
  logic        fl_rd, fl_wr, ram_rd, ram_wr;
  logic [1:0]  ram_lane_rd, ram_lane_wr, bus_oe;
  logic [19:0] fl_addr;
  logic [18:0] ram_addr;
  logic        standby, contention;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shb_bank_selector u_shb_bank_selector (
    .clk(clk), .rst_n(rst_n), .fl_en_n(fl_en_n), .ram_en1_n(ram_en1_n),
    .ram_en2(ram_en2), .oe_n(oe_n), .we_n(we_n), .ram_byte_n(ram_byte_n),
    .addr(addr), .fl_rd(fl_rd), .fl_wr(fl_wr), .ram_rd(ram_rd), .ram_wr(ram_wr),
    .ram_lane_rd(ram_lane_rd), .ram_lane_wr(ram_lane_wr), .bus_oe(bus_oe),
    .fl_addr(fl_addr), .ram_addr(ram_addr), .standby(standby),
    .contention(contention)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] s);
    {fl_en_n, ram_en1_n, ram_en2, oe_n, we_n, ram_byte_n} = s;
  endtask

  function automatic logic [9:0] comb_outs();
    return {fl_rd, fl_wr, ram_rd, ram_wr, ram_lane_rd, ram_lane_wr, bus_oe};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: flags held low under reset even with standby condition present
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(standby == 1'b0, "R10 standby in reset", 32'(standby), 32'd0);
    check(contention == 1'b0, "R10 contention in reset", 32'(contention), 32'd0);
    rst_n = 1'b1;

    // R1 R2 R6 R7 R8 R3 via vector table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      drive(VEC[v][17:11]);
      #1;
      check(comb_outs() == VEC[v][10:1], $sformatf("R1/R2/R6/R7/R8 vec%0d", v),
            32'(comb_outs()), 32'(VEC[v][10:1]));
      @(posedge clk);
      #1;
      check(standby == VEC[v][0], $sformatf("R3 standby vec%0d", v),
            32'(standby), 32'(VEC[v][0]));
      check(contention == 1'b0, $sformatf("R5 no clash vec%0d", v),
            32'(contention), 32'd0);
    end

    // R9 address split
    @(negedge clk);
    addr = 20'hABCDE;
    #1;
    check(fl_addr == 20'hABCDE, "R9 flash address", 32'(fl_addr), 32'h000ABCDE);
    check(ram_addr == 19'h2BCDE, "R9 RAM address", 32'(ram_addr), 32'h0002BCDE);

    // R4 single-cycle clash with RAM write and flash write strobes
    @(negedge clk);
    drive(7'b0_0_1_0_0_0_0);
    #1;
    check(comb_outs() == 10'd0, "R4 clash outputs off", 32'(comb_outs()), 32'd0);
    check(contention == 1'b0, "R5 flag not yet set", 32'(contention), 32'd0);
    @(negedge clk);
    drive(7'b1_0_1_0_1_0_0);
    #1;
    check(contention == 1'b1, "R5 flag set after one clash cycle", 32'(contention), 32'd1);
    check(comb_outs() == 10'b0_0_1_0_11_00_11, "R2 RAM read after clash",
          32'(comb_outs()), 32'(10'b0_0_1_0_11_00_11));
    // R5 sticky through quiet cycles
    drive(7'b1_1_0_1_1_1_1);
    repeat (5) @(posedge clk);
    #1;
    check(contention == 1'b1, "R5 flag sticky", 32'(contention), 32'd1);
    check(standby == 1'b1, "R3 standby while idle", 32'(standby), 32'd1);

    // R10 reset clears the sticky flag
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(contention == 1'b0, "R10 reset clears contention", 32'(contention), 32'd0);
    check(standby == 1'b0, "R10 reset clears standby", 32'(standby), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(contention == 1'b0, "R5 stays clear without clash", 32'(contention), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule